// File: doc/BRIEF.md
# Data-Acquisition Analog-Input Register Sequencer

This block is the analog-input control logic of a small data-acquisition card. The card sits behind a simple I/O-port style bus that makes 8-bit and 16-bit accesses. The block decodes those accesses into a channel-range register, a conversion-status register, a trigger-control register and a configuration register. It also holds a set of 16-bit DAC data registers and a 4-bit digital I/O port as plain storage.

A conversion starts when software makes a byte write to the strobe/data offset and the trigger-source field selects software triggering. A frame timer then holds the busy flag for a programmable number of reference clocks. When the frame ends, the block latches a 16-bit word from a stub converter input. Software polls the busy flag in the status register until it clears, and then reads the sample with a 16-bit read at the same offset.

The 4-bit bank field in the configuration register does not follow ordinary writes. It switches to the timer/counter bank only after three configuration writes in a row carry the key nibbles 0x3, 0xB and 0xA. Once switched, it stays there until reset.

Top module: `daq_ain_ctrl`

## Requirements
- R1: After reset, these all read zero: the sample, channel, control, DAC and digital-output registers. Configuration reads 0x00, meaning gain x1, bipolar and analog bank. Status bit 7 reads 0 and `conv_busy` is low.
- R2: A byte write to offset 0x0 starts a conversion when the control trigger field is 0 and no conversion is running. Status bit 7 and `conv_busy` read 1 from the cycle after the write.
- R3: A conversion stays busy for N+1 clock cycles. N is the value of `frame_cfg` taken at the strobe, raised to a minimum of 199 when it is smaller.
- R4: In the cycle where busy clears, the value on `conv_sample` is latched. A 16-bit read at offset 0x0 returns it. It then holds until the next conversion ends.
- R5: A strobe that arrives while busy is ignored. The running frame keeps its original end cycle.
- R6: While the control register bits 1:0 hold a nonzero trigger source, a strobe starts no conversion. Control reads back bits 1:0 with all other bits 0.
- R7: Offset 0x2 holds the first channel in bits 3:0 and the last channel in bits 7:4. It reads back as written and drives `chan_first`/`chan_last`.
- R8: Offset 0x11 holds gain in bits 1:0 (0..3 = x1, x2, x4, x8) and polarity in bit 2 (0 = bipolar). Both read back and drive `gain_code`/`unipolar`. Bit 3 reads 0.
- R9: Bits 7:4 of offset 0x11 read 0x0 in the analog bank and 0xA in the timer bank. Only three consecutive configuration writes with nibbles 0x3, 0xB, 0xA select the timer bank, which is then held until reset.
- R10: A configuration write whose nibble breaks the key sequence restarts detection. If that nibble is 0x3, it counts as the first key step.
- R11: The DAC registers at offsets 0x4 and 0x6 take 16-bit writes, read back the last value and drive `dac_out` (the channel at 0x4 in the low half). A byte read at 0x3 returns `din` in bits 3:0. A byte write at 0x3 drives bits 3:0 onto `dout`.
- R12: Access width is checked for every register. Reads return 0 except byte reads at 0x2, 0x3, 0x8, 0x9 and 0x11, and 16-bit reads at 0x0, 0x4 and 0x6. Writes change nothing except byte writes at 0x0, 0x2, 0x3, 0x9 and 0x11, and 16-bit writes at 0x4 and 0x6.
- R13: Status bit 5 follows `diff_wired` (1 = differential inputs). The other status bits, except bit 7, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the bus and the frame timer |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write access this cycle |
| bus_rd | input | 1 | Read access this cycle |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_rd` |
| frame_cfg | input | 32 | Frame interval count N taken at each accepted strobe |
| conv_sample | input | 16 | Stub converter result |
| diff_wired | input | 1 | Input wiring strap, 1 = differential |
| din | input | 4 | Digital inputs |
| dout | output | 4 | Digital outputs |
| dac_out | output | 32 | DAC register contents, channel 0 in bits 15:0 |
| chan_first | output | 4 | First channel of the selected range |
| chan_last | output | 4 | Last channel of the selected range |
| gain_code | output | 2 | Gain code 0..3 |
| unipolar | output | 1 | 1 = unipolar input range |
| timer_bank | output | 1 | 1 once the timer/counter bank is selected |
| conv_busy | output | 1 | Conversion in progress |

## Verification
A frame counter in the wrong state shows up within one frame: the busy flag in status bit 7 drops one or more cycles early or late, so the number of busy cycles per strobe is compared exactly against N+1. A counter reloaded by a second strobe would stretch that count, and a latch at the wrong edge leaves the sample read at offset 0x0 holding a stale or later `conv_sample`. A key detector in the wrong stage is visible in bits 7:4 of the configuration readback right after the third key write. The bench checks the broken, repeated-first-key and clean sequences.

// File: rtl/daq_pkg.sv
// Package daq_pkg
// Shared offsets, bit positions and decode types for the analog-input
// register sequencer. Assumes a 5-bit register offset space.
package daq_pkg;
    localparam int OFF_DATA   = 'h00;
    localparam int OFF_CHAN   = 'h02;
    localparam int OFF_DIO    = 'h03;
    localparam int OFF_DAC0   = 'h04;
    localparam int DAC_STRIDE = 2;
    localparam int OFF_STATUS = 'h08;
    localparam int OFF_CTRL   = 'h09;
    localparam int OFF_CFG    = 'h11;

    localparam int ST_BUSY_BIT = 7;
    localparam int ST_DIFF_BIT = 5;
    localparam int CFG_POL_BIT = 2;

    localparam logic [1:0] TRIG_SOFT = 2'd0;

    localparam logic [3:0] KEY_STEP0 = 4'h3;
    localparam logic [3:0] KEY_STEP1 = 4'hB;
    localparam logic [3:0] KEY_STEP2 = 4'hA;
    localparam logic [3:0] BANK_ANALOG_CODE = 4'h0;
    localparam logic [3:0] BANK_TIMER_CODE  = 4'hA;

    typedef struct packed {
        logic strobe;
        logic chan;
        logic dio;
        logic ctrl;
        logic cfg;
    } wr_sel_t;

    typedef struct packed {
        logic sample;
        logic chan;
        logic dio;
        logic status;
        logic ctrl;
        logic cfg;
    } rd_sel_t;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_GOT0 = 2'd1,
        KEY_GOT1 = 2'd2
    } key_state_t;
endpackage

// File: rtl/daq_bus_decode.sv
// Module daq_bus_decode
// Turns an offset, direction and access width into one-hot register
// selects. An access of the wrong width at a valid offset selects nothing.
// Assumes the bus never asserts read and write in the same cycle.
module daq_bus_decode
    import daq_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_DAC = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    input  logic               wide,
    output wr_sel_t            wsel,
    output rd_sel_t            rsel,
    output logic [NUM_DAC-1:0] dac_wr,
    output logic [NUM_DAC-1:0] dac_rd
);
    logic byte_wr, byte_rd, word_wr, word_rd;

    assign byte_wr = wr && !wide;
    assign byte_rd = rd && !wide;
    assign word_wr = wr && wide;
    assign word_rd = rd && wide;

    // Byte-wide register selects.
    always_comb begin
        wsel.strobe = byte_wr && (addr == ADDR_W'(OFF_DATA));
        wsel.chan   = byte_wr && (addr == ADDR_W'(OFF_CHAN));
        wsel.dio    = byte_wr && (addr == ADDR_W'(OFF_DIO));
        wsel.ctrl   = byte_wr && (addr == ADDR_W'(OFF_CTRL));
        wsel.cfg    = byte_wr && (addr == ADDR_W'(OFF_CFG));
        rsel.sample = word_rd && (addr == ADDR_W'(OFF_DATA));
        rsel.chan   = byte_rd && (addr == ADDR_W'(OFF_CHAN));
        rsel.dio    = byte_rd && (addr == ADDR_W'(OFF_DIO));
        rsel.status = byte_rd && (addr == ADDR_W'(OFF_STATUS));
        rsel.ctrl   = byte_rd && (addr == ADDR_W'(OFF_CTRL));
        rsel.cfg    = byte_rd && (addr == ADDR_W'(OFF_CFG));
    end

    // Word-wide DAC selects, one per channel at a fixed stride.
    for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac_sel
        assign dac_wr[i] = word_wr && (addr == ADDR_W'(OFF_DAC0 + DAC_STRIDE * i));
        assign dac_rd[i] = word_rd && (addr == ADDR_W'(OFF_DAC0 + DAC_STRIDE * i));
    end

    // At most one register is written per access (R12).
    always_comb begin
        if (wr === 1'b1 && !$isunknown(addr)) begin
            assert_one_write_R12: assert ($onehot0({wsel, dac_wr}))
                else $error("more than one write select active");
        end
    end
endmodule

// File: rtl/daq_frame_seq.sv
// Module daq_frame_seq
// Frame timer and sample latch. An accepted start loads a down-counter
// with the frame count (raised to MIN_FRAME), holds busy for count+1
// cycles and latches the converter word on the cycle busy clears.
// Assumes start_req is a single-cycle pulse from the register decode.
module daq_frame_seq #(
    parameter int FRAME_W   = 32,
    parameter int SAMPLE_W  = 16,
    parameter int MIN_FRAME = 199
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic [FRAME_W-1:0]  frame_cfg,
    input  logic [SAMPLE_W-1:0] conv_sample,
    output logic                busy,
    output logic [SAMPLE_W-1:0] sample
);
    localparam logic [FRAME_W-1:0] MIN_COUNT = FRAME_W'(MIN_FRAME);

    logic                busy_q;
    logic [FRAME_W-1:0]  cnt_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic [FRAME_W-1:0]  load_val;
    logic                start_ok;

    // Clamp the requested frame length to the minimum conversion time.
    assign load_val = (frame_cfg < MIN_COUNT) ? MIN_COUNT : frame_cfg;
    // A start is honoured only when no frame is running.
    assign start_ok = start_req && !busy_q;

    // Frame counter, busy flag and end-of-frame sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            sample_q <= '0;
        end else if (start_ok) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q   <= 1'b0;
                sample_q <= conv_sample;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy   = busy_q;
    assign sample = sample_q;

    // Busy only rises in answer to a start request (R2).
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start_req));

    // A running frame counts down by one each cycle; no reload (R5).
    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

    // An idle timer rests at zero (R3).
    assert_idle_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (cnt_q == '0));

    // The sample changes only on the cycle the frame ends (R4).
    assert_sample_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_q) |-> $stable(sample_q));
endmodule

// File: rtl/daq_bank_unlock.sv
// Module daq_bank_unlock
// Watches the bank nibble of every configuration write and selects the
// timer/counter bank after three consecutive key nibbles. A wrong nibble
// restarts detection, counting it as the first key if it matches.
// Assumes cfg_wr is one cycle per configuration write.
module daq_bank_unlock
    import daq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [3:0] nibble,
    output logic       timer_bank
);
    key_state_t stage_q;
    logic       bank_q;
    logic       is_key0;

    assign is_key0 = (nibble == KEY_STEP0);

    // Key sequence tracker and sticky bank select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= KEY_IDLE;
            bank_q  <= 1'b0;
        end else if (cfg_wr && !bank_q) begin
            case (stage_q)
                KEY_IDLE: stage_q <= is_key0 ? KEY_GOT0 : KEY_IDLE;
                KEY_GOT0: begin
                    if (nibble == KEY_STEP1) stage_q <= KEY_GOT1;
                    else stage_q <= is_key0 ? KEY_GOT0 : KEY_IDLE;
                end
                KEY_GOT1: begin
                    if (nibble == KEY_STEP2) begin
                        bank_q  <= 1'b1;
                        stage_q <= KEY_IDLE;
                    end else begin
                        stage_q <= is_key0 ? KEY_GOT0 : KEY_IDLE;
                    end
                end
                default: stage_q <= KEY_IDLE;
            endcase
        end
    end

    assign timer_bank = bank_q;

    // The bank switches only on the final key after the first two (R9).
    assert_bank_on_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_q) |-> $past(stage_q == KEY_GOT1 && cfg_wr && nibble == KEY_STEP2));

    // Once selected, the timer bank holds until reset (R9).
    assert_bank_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q |=> bank_q);

    // A non-key nibble always drops the tracker back to idle (R10).
    assert_break_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !bank_q && nibble != KEY_STEP0 && nibble != KEY_STEP1
         && nibble != KEY_STEP2) |=> (stage_q == KEY_IDLE));
endmodule

// File: rtl/daq_ain_ctrl.sv
// Module daq_ain_ctrl
// Top of the analog-input register sequencer: register storage, read
// multiplexer, software trigger gating, frame timer and bank unlock.
// Assumes a single bus master; read data is combinational.
module daq_ain_ctrl
    import daq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int FRAME_W   = 32,
    parameter int MIN_FRAME = 199,
    parameter int NUM_DAC   = 2,
    parameter int DIO_W     = 4,
    parameter int CHAN_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic                      bus_wide,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [FRAME_W-1:0]        frame_cfg,
    input  logic [DATA_W-1:0]         conv_sample,
    input  logic                      diff_wired,
    input  logic [DIO_W-1:0]          din,
    output logic [DIO_W-1:0]          dout,
    output logic [NUM_DAC*DATA_W-1:0] dac_out,
    output logic [CHAN_W-1:0]         chan_first,
    output logic [CHAN_W-1:0]         chan_last,
    output logic [1:0]                gain_code,
    output logic                      unipolar,
    output logic                      timer_bank,
    output logic                      conv_busy
);
    localparam int CHAN_REG_W = 2 * CHAN_W;

    wr_sel_t                 wsel;
    rd_sel_t                 rsel;
    logic [NUM_DAC-1:0]      dac_wr;
    logic [NUM_DAC-1:0]      dac_rd;
    logic [CHAN_REG_W-1:0]   chan_q;
    logic [1:0]              trig_q;
    logic [1:0]              gain_q;
    logic                    pol_q;
    logic [DIO_W-1:0]        dout_q;
    logic [DATA_W-1:0]       dac_q [NUM_DAC];
    logic [DATA_W-1:0]       sample;
    logic                    busy;
    logic                    bank_sel;
    logic                    start_req;

    daq_bus_decode #(
        .ADDR_W (ADDR_W),
        .NUM_DAC(NUM_DAC)
    ) u_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wide  (bus_wide),
        .wsel  (wsel),
        .rsel  (rsel),
        .dac_wr(dac_wr),
        .dac_rd(dac_rd)
    );

    // Software strobe counts only when the trigger field selects software.
    assign start_req = wsel.strobe && (trig_q == TRIG_SOFT);

    daq_frame_seq #(
        .FRAME_W  (FRAME_W),
        .SAMPLE_W (DATA_W),
        .MIN_FRAME(MIN_FRAME)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .frame_cfg  (frame_cfg),
        .conv_sample(conv_sample),
        .busy       (busy),
        .sample     (sample)
    );

    daq_bank_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wsel.cfg),
        .nibble    (bus_wdata[7:4]),
        .timer_bank(bank_sel)
    );

    // Byte-wide control registers: channel range, trigger, config, outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            trig_q <= TRIG_SOFT;
            gain_q <= '0;
            pol_q  <= 1'b0;
            dout_q <= '0;
        end else begin
            if (wsel.chan) chan_q <= bus_wdata[CHAN_REG_W-1:0];
            if (wsel.ctrl) trig_q <= bus_wdata[1:0];
            if (wsel.cfg) begin
                gain_q <= bus_wdata[1:0];
                pol_q  <= bus_wdata[CFG_POL_BIT];
            end
            if (wsel.dio) dout_q <= bus_wdata[DIO_W-1:0];
        end
    end

    // One 16-bit storage register per DAC channel.
    for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac
        always_ff @(posedge clk) begin
            if (!rst_n) dac_q[i] <= '0;
            else if (dac_wr[i]) dac_q[i] <= bus_wdata;
        end
        assign dac_out[i*DATA_W +: DATA_W] = dac_q[i];
    end

    // Read multiplexer; unselected or wrong-width reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (rsel.sample) bus_rdata = sample;
        if (rsel.chan)   bus_rdata[CHAN_REG_W-1:0] = chan_q;
        if (rsel.dio)    bus_rdata[DIO_W-1:0] = din;
        if (rsel.status) begin
            bus_rdata[ST_BUSY_BIT] = busy;
            bus_rdata[ST_DIFF_BIT] = diff_wired;
        end
        if (rsel.ctrl)   bus_rdata[1:0] = trig_q;
        if (rsel.cfg) begin
            bus_rdata[1:0]         = gain_q;
            bus_rdata[CFG_POL_BIT] = pol_q;
            bus_rdata[7:4]         = bank_sel ? BANK_TIMER_CODE : BANK_ANALOG_CODE;
        end
        for (int i = 0; i < NUM_DAC; i++) begin
            if (dac_rd[i]) bus_rdata = dac_q[i];
        end
    end

    assign dout       = dout_q;
    assign chan_first = chan_q[CHAN_W-1:0];
    assign chan_last  = chan_q[CHAN_REG_W-1:CHAN_W];
    assign gain_code  = gain_q;
    assign unipolar   = pol_q;
    assign timer_bank = bank_sel;
    assign conv_busy  = busy;

    // A strobe under a hardware trigger source leaves the timer idle (R6).
    assert_hw_trig_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_wide && bus_addr == ADDR_W'(OFF_DATA)
         && trig_q != TRIG_SOFT && !busy) |=> !busy);

    // The channel register moves only after a byte write to its offset (R7).
    assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wsel.chan) |-> $stable(chan_q));

    // The digital outputs move only after a byte write to their offset (R11).
    assert_dout_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wsel.dio) |-> $stable(dout));
endmodule

// File: tb/daq_ain_ctrl_bench.sv
// Directed bench for daq_ain_ctrl: one task per scenario.
module daq_ain_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] frame_cfg = 32'd0;
    logic [15:0] conv_sample = '0;
    logic        diff_wired = 1'b0;
    logic [3:0]  din = '0;
    logic [3:0]  dout;
    logic [31:0] dac_out;
    logic [3:0]  chan_first, chan_last;
    logic [1:0]  gain_code;
    logic        unipolar, timer_bank, conv_busy;

    int checks = 0;
    int errors = 0;

    daq_ain_ctrl u_daq_ain_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .frame_cfg(frame_cfg), .conv_sample(conv_sample),
        .diff_wired(diff_wired), .din(din), .dout(dout), .dac_out(dac_out),
        .chan_first(chan_first), .chan_last(chan_last), .gain_code(gain_code),
        .unipolar(unipolar), .timer_bank(timer_bank), .conv_busy(conv_busy)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic wide, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wide = wide; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic wide, output logic [15:0] d);
        bus_addr = a; bus_wide = wide; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // Counts busy negedges from now; optionally re-strobes at count k.
    task automatic busy_len(input int k, output int n);
        logic [15:0] st;
        n = 0;
        rd(5'h08, 1'b0, st);
        while (st[7] && n < 100000) begin
            n++;
            if (n == k) begin
                bus_addr = 5'h00; bus_wide = 1'b0; bus_wdata = 16'h0; bus_wr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
            end else begin
                @(negedge clk);
            end
            rd(5'h08, 1'b0, st);
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(5'h00, 1'b1, d); check("R1 sample", d, 0);
        rd(5'h02, 1'b0, d); check("R1 chan", d, 0);
        rd(5'h09, 1'b0, d); check("R1 ctrl", d, 0);
        rd(5'h11, 1'b0, d); check("R1 cfg", d, 0);
        rd(5'h08, 1'b0, d); check("R1 status", d, 0);
        rd(5'h04, 1'b1, d); check("R1 dac0", d, 0);
        check("R1 dout", dout, 0);
        check("R1 busy", conv_busy, 0);
    endtask

    task automatic t_conv_min();
        int n;
        logic [15:0] d;
        frame_cfg = 32'd5;
        conv_sample = 16'hBEEF;
        wr(5'h00, 1'b0, 16'h00);
        check("R2 busy after strobe", conv_busy, 1);
        busy_len(0, n);
        check("R3 clamped frame length", n, 200);
        rd(5'h00, 1'b1, d); check("R4 sample latched", d, 16'hBEEF);
        conv_sample = 16'h1234;
        repeat (3) @(negedge clk);
        rd(5'h00, 1'b1, d); check("R4 sample held", d, 16'hBEEF);
    endtask

    task automatic t_conv_long_restrobe();
        int n;
        logic [15:0] d;
        frame_cfg = 32'd250;
        conv_sample = 16'h5A5A;
        wr(5'h00, 1'b0, 16'h00);
        busy_len(50, n);
        check("R5 restrobe ignored, length", n, 251);
        check("R3 busy port low at end", conv_busy, 0);
        rd(5'h00, 1'b1, d); check("R4 second sample", d, 16'h5A5A);
    endtask

    task automatic t_hw_trigger();
        logic [15:0] d;
        wr(5'h09, 1'b0, 16'hFF);
        rd(5'h09, 1'b0, d); check("R6 ctrl readback", d, 16'h0003);
        wr(5'h00, 1'b0, 16'h00);
        rd(5'h08, 1'b0, d); check("R6 no start under hw trigger", d[7], 0);
        @(negedge clk);
        check("R6 busy stays low", conv_busy, 0);
        wr(5'h09, 1'b0, 16'h00);
    endtask

    task automatic t_chan_cfg();
        logic [15:0] d;
        wr(5'h02, 1'b0, 16'h00C5);
        rd(5'h02, 1'b0, d); check("R7 chan readback", d, 16'h00C5);
        check("R7 chan ports", {chan_last, chan_first}, 8'hC5);
        wr(5'h11, 1'b0, 16'h000F);
        rd(5'h11, 1'b0, d); check("R8 cfg gain/pol readback", d, 16'h0007);
        check("R8 gain/unipolar ports", {unipolar, gain_code}, 3'b111);
        wr(5'h11, 1'b0, 16'h0002);
        check("R8 gain x4 bipolar", {unipolar, gain_code}, 3'b010);
    endtask

    task automatic t_unlock();
        logic [15:0] d;
        wr(5'h11, 1'b0, 16'h0030);
        wr(5'h11, 1'b0, 16'h00B0);
        wr(5'h11, 1'b0, 16'h0050);
        wr(5'h11, 1'b0, 16'h00A0);
        rd(5'h11, 1'b0, d); check("R10 broken sequence keeps analog bank", d, 16'h0000);
        check("R10 timer_bank low", timer_bank, 0);
        wr(5'h11, 1'b0, 16'h00B1);
        wr(5'h11, 1'b0, 16'h0031);
        wr(5'h11, 1'b0, 16'h0031);
        wr(5'h11, 1'b0, 16'h00B1);
        rd(5'h11, 1'b0, d); check("R9 two keys not enough", d[7:4], 4'h0);
        wr(5'h11, 1'b0, 16'h00A1);
        rd(5'h11, 1'b0, d); check("R9 timer bank after keys", d, 16'h00A1);
        check("R9 timer_bank port", timer_bank, 1);
        wr(5'h11, 1'b0, 16'h0003);
        rd(5'h11, 1'b0, d); check("R9 bank sticky", d, 16'h00A3);
    endtask

    task automatic t_dac_dio();
        logic [15:0] d;
        wr(5'h04, 1'b1, 16'hCAFE);
        wr(5'h06, 1'b1, 16'h0F0F);
        rd(5'h04, 1'b1, d); check("R11 dac0 readback", d, 16'hCAFE);
        rd(5'h06, 1'b1, d); check("R11 dac1 readback", d, 16'h0F0F);
        check("R11 dac_out", dac_out, 32'h0F0FCAFE);
        din = 4'h9;
        rd(5'h03, 1'b0, d); check("R11 din read", d, 16'h0009);
        wr(5'h03, 1'b0, 16'h005C);
        check("R11 dout", dout, 4'hC);
    endtask

    task automatic t_gating();
        logic [15:0] d;
        rd(5'h01, 1'b0, d); check("R12 read unmapped", d, 0);
        rd(5'h00, 1'b0, d); check("R12 byte read of sample", d, 0);
        rd(5'h02, 1'b1, d); check("R12 word read of chan", d, 0);
        rd(5'h04, 1'b0, d); check("R12 byte read of dac", d, 0);
        wr(5'h02, 1'b1, 16'h0011);
        rd(5'h02, 1'b0, d); check("R12 word write to chan ignored", d, 16'h00C5);
        wr(5'h04, 1'b0, 16'h0077);
        rd(5'h04, 1'b1, d); check("R12 byte write to dac ignored", d, 16'hCAFE);
        wr(5'h08, 1'b0, 16'h00FF);
        rd(5'h08, 1'b0, d); check("R12 status write ignored", d, 16'h0000);
        wr(5'h00, 1'b1, 16'h0000);
        check("R12 word write at strobe no start", conv_busy, 0);
    endtask

    task automatic t_status_wiring();
        logic [15:0] d;
        diff_wired = 1'b1;
        rd(5'h08, 1'b0, d); check("R13 differential", d, 16'h0020);
        diff_wired = 1'b0;
        rd(5'h08, 1'b0, d); check("R13 single-ended", d, 16'h0000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_conv_min();
        t_conv_long_restrobe();
        t_hw_trigger();
        t_chan_cfg();
        t_unlock();
        t_dac_dio();
        t_gating();
        t_status_wiring();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule